// File: doc/BRIEF.md
# Serial DAC Command Receiver with Chain Output

This block is the digital front end of a serially loaded digital-to-analog converter. A host drives a serial clock, a serial data line and an active-low load strobe. While the strobe is low, bits are shifted MSB-first into a 32-bit shift register. When the strobe returns high, the block decodes the most recent 24 bits and executes the command against three registers: the input register, the DAC code register and the output-range mode register. The analog stage reads the DAC code and the mode.

The last shift-register stage drives a serial output. Several receivers can be chained by wiring each serial output to the next device's serial input. The clock and strobe are shared, so every device in the chain acts on the same strobe edge. All serial pins are brought into one system clock domain through two-flop synchronizers. An asynchronous active-low clear zeroes the registers. If that clear arrives shortly after a load, a flag tells the host that the output range must be sent again. A resolution parameter of 16, 14 or 12 bits sets how many data bits are kept.

Top module: `dac_cmd_rx`

## Requirements
- R1: While `ld_n` is low, each rising edge of `sclk` shifts the bit on `sdi` into the shift register. Frames are sent MSB-first.
- R2: On the rising edge of `ld_n`, the command is the 4 bits received 24th to 21st from the end, and the data is the last 16 bits received. As a result, a 24-bit frame (command, 4 filler bits, data) and a 32-bit frame (8 leading filler bits, then the same 24 bits) decode identically.
- R3: `sclk` edges that occur while `ld_n` is high are ignored. They leave the shift register and `sdo` unchanged.
- R4: After the falling `sclk` edge that follows the k-th shifted bit, `sdo` carries bit k-31 (counting from 1), or 0 if k < 32. `sdo` changes only after falling `sclk` edges.
- R5: Command codes:
  - 0000: write the data to `in_code`.
  - 0001: copy `in_code` to `dac_code`.
  - 1000 to 1101 (1000 and 1001 unipolar, 1010 to 1101 bipolar): write the code to `range_mode` and the data to both `in_code` and `dac_code`.
  - Any other code: no operation.
- R6: With RES_BITS of 14 or 12, the lowest 16-RES_BITS bits of the data field are stored as zero.
- R7: After power-on reset:
  - `range_mode` is 1000.
  - `in_code`, `dac_code`, `sdo` and `reload_req` are 0.
- R8: `clr_n` low asynchronously zeroes the shift register, `sdo`, `in_code`, `dac_code` and `range_mode`. An update command (0001) sent after a clear leaves `dac_code` at 0.
- R9: A clear that begins within HAZ_CYC system clocks after the strobe rise sets `reload_req`. A clear that begins later does not set it. `reload_req` is cleared when a range command executes.
- R10: Two chained devices that share `sclk` and `ld_n` accept a 56-bit stream in one strobe window. The downstream device executes the first 24 bits, and the upstream device executes the last 32 bits as a 32-bit frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| ld_n | input | 1 | Load strobe; low shifts, rising edge executes |
| clr_n | input | 1 | Asynchronous clear, active low |
| sdo | output | 1 | Serial data out to the next device |
| in_code | output | 16 | Input register |
| dac_code | output | 16 | DAC code register |
| range_mode | output | 4 | Output range mode register |
| reload_req | output | 1 | Range must be reloaded after a clear hazard |

## Verification
The embedded assertions check the following on every cycle:
- `sdo` moves only after a detected falling serial edge.
- `dac_code` moves only on a strobe rise.
- The mode register holds only legal codes.
- The masked low data bits stay zero.
- `reload_req` rises only while the synchronized clear is low.

Other behaviours can only be shown by the bench's scenarios, using a reference model that tracks the full bit history:
- Decoding from the last 24 bits for both frame lengths.
- The 32-bit delay to `sdo` and two-device chaining.
- Ignored clocks while the strobe is high.
- The clear hazard window on both sides of its limit.

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx #(
  parameter int RES_BITS = 16,
  parameter int HAZ_CYC  = 20,
  parameter int SR_LEN   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        sdi,
  input  logic        ld_n,
  input  logic        clr_n,
  output logic        sdo,
  output logic [15:0] in_code,
  output logic [15:0] dac_code,
  output logic [3:0]  range_mode,
  output logic        reload_req
);
  localparam int DW = 16;
  localparam int WW = $clog2(HAZ_CYC + 1);
  localparam logic [DW-1:0] DMASK = {DW{1'b1}} << (DW - RES_BITS);
  localparam logic [3:0] MODE_PON  = 4'b1000;
  localparam logic [3:0] CMD_WRITE = 4'b0000;
  localparam logic [3:0] CMD_UPD   = 4'b0001;

  logic [2:0] ld_p, sck_p;
  logic [1:0] sdi_p, clr_p;
  logic [SR_LEN-1:0] sr;
  logic [WW-1:0] win;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ld_p  <= 3'b111;
      sck_p <= '0;
      sdi_p <= '0;
      clr_p <= 2'b11;
    end else begin
      ld_p  <= {ld_p[1:0], ld_n};
      sck_p <= {sck_p[1:0], sclk};
      sdi_p <= {sdi_p[0], sdi};
      clr_p <= {clr_p[0], clr_n};
    end

  wire ld_lo    = ~ld_p[1];
  wire ld_rise  = ld_p[1] & ~ld_p[2];
  wire sck_rise = sck_p[1] & ~sck_p[2] & ld_lo;
  wire sck_fall = ~sck_p[1] & sck_p[2] & ld_lo;

  wire [3:0]    cmd      = sr[23:20];
  wire [DW-1:0] dat      = sr[DW-1:0] & DMASK;
  wire          is_range = (cmd >= 4'd8) && (cmd <= 4'd13);

  always_ff @(posedge clk or negedge rst_n or negedge clr_n)
    if (!rst_n) begin
      sr         <= '0;
      sdo        <= 1'b0;
      in_code    <= '0;
      dac_code   <= '0;
      range_mode <= MODE_PON;
    end else if (!clr_n) begin
      sr         <= '0;
      sdo        <= 1'b0;
      in_code    <= '0;
      dac_code   <= '0;
      range_mode <= '0;
    end else begin
      if (sck_rise) sr <= {sr[SR_LEN-2:0], sdi_p[1]};
      if (sck_fall) sdo <= sr[SR_LEN-1];
      if (ld_rise) begin
        if (cmd == CMD_WRITE) in_code <= dat;
        else if (cmd == CMD_UPD) dac_code <= in_code;
        else if (is_range) begin
          range_mode <= cmd;
          in_code    <= dat;
          dac_code   <= dat;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      win        <= '0;
      reload_req <= 1'b0;
    end else begin
      if (ld_rise) win <= WW'(HAZ_CYC);
      else if (win != '0) win <= win - WW'(1);
      if (!clr_p[1] && (win != '0 || ld_rise)) reload_req <= 1'b1;
      else if (ld_rise && is_range && clr_n) reload_req <= 1'b0;
    end

  a_r4_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !$stable(sdo) |-> $past(sck_fall));

  a_r5_dac_on_strobe: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !$past(ld_rise) |-> $stable(dac_code));

  a_r5_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (range_mode == 4'd0) || (range_mode >= 4'd8 && range_mode <= 4'd13));

  a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_code & ~DMASK) == '0) && ((dac_code & ~DMASK) == '0));

  a_r9_flag_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reload_req) |-> !$past(clr_p[1]));
endmodule

// File: tb/sim_dac_cmd_rx.sv
`timescale 1ns/1ps
module sim_dac_cmd_rx;
  localparam int HAZ = 20;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdi = 1'b0, ld_n = 1'b1, clr_n = 1'b1;
  logic sdo0, sdo1, rl0, rl1;
  logic [15:0] in0, in1, dac0, dac1;
  logic [3:0] md0, md1;

  always #2.5 clk = ~clk;

  dac_cmd_rx #(.RES_BITS(16), .HAZ_CYC(HAZ)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .ld_n(ld_n), .clr_n(clr_n),
    .sdo(sdo0), .in_code(in0), .dac_code(dac0), .range_mode(md0), .reload_req(rl0));

  dac_cmd_rx #(.RES_BITS(12), .HAZ_CYC(HAZ)) u1 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdo0), .ld_n(ld_n), .clr_n(clr_n),
    .sdo(sdo1), .in_code(in1), .dac_code(dac1), .range_mode(md1), .reload_req(rl1));

  int checks = 0, errors = 0;
  logic cmp_en = 1'b0;
  logic hist[$];
  logic [15:0] e_in[2], e_dac[2];
  logic [3:0]  e_mode[2];
  logic        e_rl[2];

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic gb(input int k);
    return (hist.size() > k) ? hist[hist.size() - 1 - k] : 1'b0;
  endfunction

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      e_in[d] = '0; e_dac[d] = '0; e_mode[d] = 4'b1000; e_rl[d] = 1'b0;
    end
    hist.delete();
  endtask

  task automatic model_exec();
    for (int d = 0; d < 2; d++) begin
      logic [3:0] c;
      logic [15:0] v;
      int off = 32 * d;
      for (int j = 0; j < 4; j++) c[j] = gb(off + 20 + j);
      for (int j = 0; j < 16; j++) v[j] = gb(off + j);
      v = v & ((d == 1) ? 16'hFFF0 : 16'hFFFF);
      if (c == 4'b0000) e_in[d] = v;
      else if (c == 4'b0001) e_dac[d] = e_in[d];
      else if (c >= 4'd8 && c <= 4'd13) begin
        e_mode[d] = c; e_in[d] = v; e_dac[d] = v; e_rl[d] = 1'b0;
      end
    end
  endtask

  task automatic model_clear(input logic hazard);
    for (int d = 0; d < 2; d++) begin
      e_in[d] = '0; e_dac[d] = '0; e_mode[d] = '0;
      if (hazard) e_rl[d] = 1'b1;
    end
    hist.delete();
  endtask

  always @(negedge clk)
    if (cmp_en) begin
      chk("R5", "in0", in0, e_in[0]);
      chk("R5", "dac0", dac0, e_dac[0]);
      chk("R5", "mode0", {12'h0, md0}, {12'h0, e_mode[0]});
      chk("R9", "reload0", {15'h0, rl0}, {15'h0, e_rl[0]});
      chk("R10", "in1", in1, e_in[1]);
      chk("R10", "dac1", dac1, e_dac[1]);
      chk("R10", "mode1", {12'h0, md1}, {12'h0, e_mode[1]});
      chk("R9", "reload1", {15'h0, rl1}, {15'h0, e_rl[1]});
    end

  task automatic send_bit(input logic b, input logic record);
    sdi = b;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    if (record) hist.push_back(b);
    repeat (4) @(negedge clk);
    chk(record ? "R4" : "R3", "sdo0", {15'h0, sdo0}, {15'h0, gb(31)});
  endtask

  task automatic frame(input logic [63:0] w, input int n, input int clr_after);
    ld_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i], 1'b1);
    repeat (2) @(negedge clk);
    ld_n = 1'b1;
    cmp_en = 1'b0;
    if (clr_after >= 0) begin
      repeat (clr_after) @(negedge clk);
      clr_n = 1'b0;
      model_exec();
      model_clear(clr_after <= HAZ);
      repeat (3) @(negedge clk);
      clr_n = 1'b1;
    end else begin
      repeat (6) @(negedge clk);
      model_exec();
    end
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
  endtask

  task automatic do_clear();
    repeat (HAZ + 5) @(negedge clk);
    cmp_en = 1'b0;
    clr_n = 1'b0;
    repeat (3) @(negedge clk);
    clr_n = 1'b1;
    model_clear(1'b0);
    repeat (3) @(negedge clk);
    cmp_en = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R7 power-on state
    chk("R7", "mode0", {12'h0, md0}, 16'h0008);
    chk("R7", "dac0", dac0, 16'h0000);
    chk("R7", "in0", in0, 16'h0000);
    chk("R7", "sdo0", {15'h0, sdo0}, 16'h0000);
    chk("R7", "reload0", {15'h0, rl0}, 16'h0000);
    cmp_en = 1'b1;

    // R5 update after power-on keeps zero
    frame({40'h0, 4'b0001, 4'h0, 16'hFFFF}, 24, -1);
    chk("R5", "dac0 after update", dac0, 16'h0000);
    // R1 R2 R5 range command in a 24-bit frame
    frame({40'h0, 4'b1010, 4'h7, 16'hABCD}, 24, -1);
    chk("R2", "mode0 range", {12'h0, md0}, 16'h000A);
    chk("R1", "dac0 range", dac0, 16'hABCD);
    // R5 write-only then update
    frame({40'h0, 4'b0000, 4'h0, 16'h1234}, 24, -1);
    chk("R5", "in0 write", in0, 16'h1234);
    chk("R5", "dac0 hold", dac0, 16'hABCD);
    frame({40'h0, 4'b0001, 4'h0, 16'h0000}, 24, -1);
    chk("R5", "dac0 update", dac0, 16'h1234);
    // R5 reserved code is no-op
    frame({40'h0, 4'b0110, 4'h0, 16'h5555}, 24, -1);
    chk("R5", "in0 reserved", in0, 16'h1234);
    // R2 32-bit frame with leading filler
    frame({32'h0, 8'hFF, 4'b1001, 4'h0, 16'h5A5A}, 32, -1);
    chk("R2", "mode0 32b", {12'h0, md0}, 16'h0009);
    chk("R2", "dac0 32b", dac0, 16'h5A5A);
    // R3 clocks while strobe high are ignored
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
    frame({40'h0, 4'b0000, 4'h0, 16'h0F0F}, 24, -1);
    chk("R3", "in0 after ignored clocks", in0, 16'h0F0F);
    // R8 clear then update keeps zero
    do_clear();
    chk("R8", "mode0 cleared", {12'h0, md0}, 16'h0000);
    frame({40'h0, 4'b0001, 4'h0, 16'hFFFF}, 24, -1);
    chk("R8", "dac0 after clear+update", dac0, 16'h0000);
    // R9 hazard window
    frame({40'h0, 4'b1011, 4'h0, 16'h2222}, 24, 3);
    chk("R9", "reload0 set", {15'h0, rl0}, 16'h0001);
    frame({40'h0, 4'b1100, 4'h0, 16'h3333}, 24, -1);
    chk("R9", "reload0 cleared", {15'h0, rl0}, 16'h0000);
    frame({40'h0, 4'b1101, 4'h0, 16'h4444}, 24, HAZ + 10);
    chk("R9", "reload0 outside window", {15'h0, rl0}, 16'h0000);
    // R10 chain: 24 bits for downstream, then 32-bit frame for upstream
    do_clear();
    frame({8'h0, 4'b1011, 4'h0, 16'hC3F7, 8'hA5, 4'b1100, 4'h0, 16'h1357}, 56, -1);
    chk("R10", "mode1 chain", {12'h0, md1}, 16'h000B);
    chk("R6", "in1 masked", in1, 16'hC3F0);
    chk("R10", "mode0 chain", {12'h0, md0}, 16'h000C);
    chk("R10", "in0 chain", in0, 16'h1357);

    cmp_en = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule